// File: doc/BRIEF.md
# GPIO Function Command Handler

This block sits behind a host byte channel and interprets short command frames that steer four dual-use pins. A pin serves as a slave-select output until the host turns it into a general-purpose pin. Each frame opens with a function byte. Some functions take one data byte after it. The block holds the GPIO-enable mask and a 2-bit drive-mode field per pin, and it presents both to the pin drivers. A sample command latches the synchronized pin levels into a one-byte buffer without answering. A separate fetch command then returns that byte on the response stream. The buffer is consumed by that single fetch.

Command bytes arrive on a valid/ready stream, and `cmd_last` marks the final byte of a frame. Responses leave on a second valid/ready stream. While a response byte waits unaccepted, the block accepts no command byte. A response byte stays unchanged until the sink takes it. A new command may be accepted in the same cycle that the pending response is taken.

Top module: `gpio_fn_handler`

## Requirements
- R1: After reset, `gpio_en` is 0 (all pins are slave selects), `pin_mode` is 0, `rsp_valid` is 0 and `cmd_err` is 0.
- R2: The frame {8'hF6, d} sets `gpio_en` to d[3:0], where bit n selects pin n. A 1 means GPIO and a 0 means slave select. Bits d[7:4] have no effect.
- R3: A pin whose enable bit rises through 8'hF6 gets mode 2'b00 (quasi-bidirectional). Pins already enabled, and pins being disabled, keep their mode.
- R4: The frame {8'hF7, d} sets `pin_mode` to d. Pin n's mode sits in bits [2n+1:2n]: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain.
- R5: A frame holding only 8'hF6 or only 8'hF7 (`cmd_last` set on the function byte) changes nothing, and the next byte is parsed as a function byte.
- R6: The frame {8'hF5} stores a byte in the buffer. Bits [3:0] hold the synchronized pin levels ANDed with `gpio_en`, and bits [7:4] are 0. Pin levels must be steady for two clocks before the sample is accepted. No response byte is produced.
- R7: The frame {8'h01} (fetch) produces exactly one response byte, visible on the cycle after the command is accepted. It carries the buffer if the buffer is valid. A fetch invalidates the buffer, and a fetch of an invalid buffer returns 8'h00.
- R8: A function byte that is not 8'hF5, 8'hF6, 8'hF7 or 8'h01 raises `cmd_err` for the one cycle after its acceptance and changes no state.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `cmd_ready` is low.
- R10: Bytes that follow a complete command (or an unknown function byte) in the same frame are dropped up to and including the byte marked `cmd_last`.
- R11: If an 8'hF5 is accepted in the cycle that a pending response is taken, the sink receives the old byte, and the next fetch returns the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Command byte |
| cmd_last | input | 1 | Final byte of the frame |
| rsp_valid | output | 1 | Response byte offered |
| rsp_ready | input | 1 | Sink takes the response byte |
| rsp_data | output | 8 | Response byte |
| pin_level | input | 4 | Raw pin levels, asynchronous |
| gpio_en | output | 4 | Per-pin GPIO enable mask |
| pin_mode | output | 8 | Per-pin 2-bit drive mode |
| cmd_err | output | 1 | Unknown function byte pulse |

## Verification
Two events can land on one clock edge: a sample command loading the buffer, and the sink draining the earlier fetch result. The bench provokes this by holding `rsp_ready` low behind a fetch, changing the pins, then raising `rsp_ready` together with an offered 8'hF5. The check passes when the byte taken on that edge is the old capture and a following fetch returns the new pin levels.

// File: rtl/gpiofn_pkg.sv
package gpiofn_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FN_SAMPLE = 8'hF5;
  localparam logic [BYTE_W-1:0] FN_ENABLE = 8'hF6;
  localparam logic [BYTE_W-1:0] FN_MODE   = 8'hF7;
  localparam logic [BYTE_W-1:0] FN_FETCH  = 8'h01;

  typedef enum logic [1:0] {
    ST_ID   = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } parse_st_t;

  typedef enum logic {
    WR_ENABLE = 1'b0,
    WR_MODE   = 1'b1
  } wr_kind_t;
endpackage

// File: rtl/gpiofn_sync.sv
module gpiofn_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpiofn_parse.sv
module gpiofn_parse
  import gpiofn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_last,
  input  logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              cap_stb,
  output logic              fetch_stb,
  output logic              wr_en_stb,
  output logic              wr_mode_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              err_o
);
  parse_st_t st_q, st_d;
  wr_kind_t  kind_q, kind_d;
  logic      err_q, err_d;
  logic      acc;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign wr_data   = cmd_data;
  assign err_o     = err_q;

  always_comb begin
    st_d        = st_q;
    kind_d      = kind_q;
    err_d       = 1'b0;
    cap_stb     = 1'b0;
    fetch_stb   = 1'b0;
    wr_en_stb   = 1'b0;
    wr_mode_stb = 1'b0;
    if (acc) begin
      unique case (st_q)
        ST_ID: begin
          if (cmd_data == FN_SAMPLE) begin
            cap_stb = 1'b1;
            st_d    = cmd_last ? ST_ID : ST_SKIP;
          end else if (cmd_data == FN_FETCH) begin
            fetch_stb = 1'b1;
            st_d      = cmd_last ? ST_ID : ST_SKIP;
          end else if (cmd_data == FN_ENABLE || cmd_data == FN_MODE) begin
            kind_d = (cmd_data == FN_MODE) ? WR_MODE : WR_ENABLE;
            st_d   = cmd_last ? ST_ID : ST_DATA;
          end else begin
            err_d = 1'b1;
            st_d  = cmd_last ? ST_ID : ST_SKIP;
          end
        end
        ST_DATA: begin
          wr_en_stb   = (kind_q == WR_ENABLE);
          wr_mode_stb = (kind_q == WR_MODE);
          st_d        = cmd_last ? ST_ID : ST_SKIP;
        end
        ST_SKIP: begin
          if (cmd_last) st_d = ST_ID;
        end
        default: st_d = ST_ID;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_ID;
      kind_q <= WR_ENABLE;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      err_q  <= err_d;
    end
  end

  // R8: an error pulse is always caused by a function byte taken in ST_ID
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(acc && st_q == ST_ID));
  // R10: at most one action per accepted byte
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_stb, fetch_stb, wr_en_stb, wr_mode_stb, err_d}));
endmodule

// File: rtl/gpiofn_cfg.sv
module gpiofn_cfg
  import gpiofn_pkg::*;
#(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned MODE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_stb,
  input  logic                    wr_mode_stb,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [NPINS-1:0]        en_o,
  output logic [NPINS*MODE_W-1:0] mode_o
);
  logic [NPINS-1:0] en_q;
  assign en_o = en_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [MODE_W-1:0] mode_q;
    logic              fresh;
    assign fresh = wr_en_stb && wr_data[p] && !en_q[p];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[p] <= 1'b0;
        mode_q  <= '0;
      end else begin
        if (wr_en_stb) en_q[p] <= wr_data[p];
        if (wr_mode_stb)  mode_q <= wr_data[p*MODE_W +: MODE_W];
        else if (fresh)   mode_q <= '0;
      end
    end
    assign mode_o[p*MODE_W +: MODE_W] = mode_q;

    // R3: a pin that has just become GPIO sits in quasi-bidirectional mode
    p_fresh_quasi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[p]) |-> mode_q == '0);
  end

  // R2: the mask only moves on an enable write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_stb |=> $stable(en_q));
  // R4: modes only move on a mode write or a fresh enable
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_stb && !wr_mode_stb |=> $stable(mode_o));
endmodule

// File: rtl/gpiofn_snap.sv
module gpiofn_snap
  import gpiofn_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [NPINS-1:0]  en_i,
  input  logic              cap_stb,
  input  logic              fetch_stb,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  localparam int unsigned PAD_W = BYTE_W - NPINS;

  logic [BYTE_W-1:0] buf_q;
  logic              buf_vld_q;
  logic              rv_q;
  logic [BYTE_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_vld_q <= 1'b0;
    end else if (cap_stb) begin
      buf_q     <= {{PAD_W{1'b0}}, pins_i & en_i};
      buf_vld_q <= 1'b1;
    end else if (fetch_stb) begin
      buf_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (fetch_stb) begin
      rv_q <= 1'b1;
      rd_q <= buf_vld_q ? buf_q : '0;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

  // R9: a waiting response holds its byte
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q && !rsp_ready |=> rv_q && $stable(rd_q));
  // R7: a fetch consumes the buffer and offers a byte
  p_fetch_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |=> !buf_vld_q && rv_q);
  // R6: a sample validates the buffer with zero upper bits
  p_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> buf_vld_q && buf_q[BYTE_W-1:NPINS] == '0);
endmodule

// File: rtl/gpio_fn_handler.sv
module gpio_fn_handler
  import gpiofn_pkg::*;
#(
  parameter int unsigned NPINS       = 4,
  parameter int unsigned MODE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [7:0]              cmd_data,
  input  logic                    cmd_last,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [7:0]              rsp_data,
  input  logic [NPINS-1:0]        pin_level,
  output logic [NPINS-1:0]        gpio_en,
  output logic [NPINS*MODE_W-1:0] pin_mode,
  output logic                    cmd_err
);
  logic              cap_stb, fetch_stb, wr_en_stb, wr_mode_stb;
  logic [BYTE_W-1:0] wr_data;
  logic [NPINS-1:0]  pins_sync;

  gpiofn_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_level), .sync_o(pins_sync));

  gpiofn_parse u_parse (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .cap_stb(cap_stb), .fetch_stb(fetch_stb),
    .wr_en_stb(wr_en_stb), .wr_mode_stb(wr_mode_stb),
    .wr_data(wr_data), .err_o(cmd_err));

  gpiofn_cfg #(.NPINS(NPINS), .MODE_W(MODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en_stb(wr_en_stb), .wr_mode_stb(wr_mode_stb),
    .wr_data(wr_data), .en_o(gpio_en), .mode_o(pin_mode));

  gpiofn_snap #(.NPINS(NPINS)) u_snap (
    .clk(clk), .rst_n(rst_n),
    .pins_i(pins_sync), .en_i(gpio_en),
    .cap_stb(cap_stb), .fetch_stb(fetch_stb),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  // R9: no command byte is taken while a response is blocked
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && cmd_valid |=> $stable(gpio_en) && $stable(pin_mode));
endmodule

// File: tb/gpio_fn_handler_bench.sv
module gpio_fn_handler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = '0;
  logic       cmd_last = 1'b0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [3:0] pin_level = '0;
  logic [3:0] gpio_en;
  logic [7:0] pin_mode;
  logic       cmd_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_fn_handler u_gpio_fn_handler (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .pin_level(pin_level),
    .gpio_en(gpio_en), .pin_mode(pin_mode), .cmd_err(cmd_err));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last);
    cmd_valid = 1'b1; cmd_data = b; cmd_last = last;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_last = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 gpio_en", {4'h0, gpio_en}, 8'h00);
    chk("R1 pin_mode", pin_mode, 8'h00);
    chk("R1 rsp_valid", {7'h0, rsp_valid}, 8'h00);
    chk("R1 cmd_err", {7'h0, cmd_err}, 8'h00);
  endtask

  task automatic t_enable_mode;
    send_byte(8'hF6, 0); send_byte(8'h05, 1);
    chk("R2 enable 05", {4'h0, gpio_en}, 8'h05);
    send_byte(8'hF7, 0); send_byte(8'hFF, 1);
    chk("R4 mode FF", pin_mode, 8'hFF);
    send_byte(8'hF6, 0); send_byte(8'hF3, 1);
    chk("R2 upper bits ignored", {4'h0, gpio_en}, 8'h03);
    chk("R3 fresh pin quasi", pin_mode, 8'hF3);
    send_byte(8'hF7, 0); send_byte(8'h1B, 1);
    chk("R4 mode 1B", pin_mode, 8'h1B);
  endtask

  task automatic t_truncated;
    send_byte(8'hF7, 1);
    chk("R5 trunc mode", pin_mode, 8'h1B);
    send_byte(8'hF6, 1);
    chk("R5 trunc enable", {4'h0, gpio_en}, 8'h03);
    chk("R5 no error", {7'h0, cmd_err}, 8'h00);
    send_byte(8'hF7, 0); send_byte(8'h2D, 1);
    chk("R5 parser resyncs", pin_mode, 8'h2D);
  endtask

  task automatic t_unknown_drain;
    send_byte(8'h42, 0);
    chk("R8 err pulse", {7'h0, cmd_err}, 8'h01);
    send_byte(8'hF6, 0);
    chk("R8 err one cycle", {7'h0, cmd_err}, 8'h00);
    send_byte(8'h0F, 1);
    chk("R8 state untouched", {4'h0, gpio_en}, 8'h03);
    send_byte(8'hF5, 0); send_byte(8'hF6, 0); send_byte(8'h0F, 1);
    chk("R10 trailing bytes dropped", {4'h0, gpio_en}, 8'h03);
    send_byte(8'h01, 0); send_byte(8'hF7, 1);
    idle(1);
    chk("R10 trailing after fetch", pin_mode, 8'h2D);
  endtask

  task automatic t_sample_fetch;
    pin_level = 4'hE;
    idle(3);
    send_byte(8'hF5, 1);
    chk("R6 no response", {7'h0, rsp_valid}, 8'h00);
    send_byte(8'h01, 1);
    chk("R7 rsp valid", {7'h0, rsp_valid}, 8'h01);
    chk("R6 masked capture", rsp_data, 8'h02);
    idle(1);
    chk("R7 single byte", {7'h0, rsp_valid}, 8'h00);
    send_byte(8'h01, 1);
    chk("R7 invalid buffer", rsp_data, 8'h00);
    idle(1);
  endtask

  task automatic t_backpressure_overlap;
    send_byte(8'hF6, 0); send_byte(8'h0F, 1);
    pin_level = 4'h5;
    idle(3);
    send_byte(8'hF5, 1);
    rsp_ready = 1'b0;
    send_byte(8'h01, 1);
    chk("R9 rsp data", rsp_data, 8'h05);
    pin_level = 4'hA;
    idle(3);
    chk("R9 held valid", {7'h0, rsp_valid}, 8'h01);
    chk("R9 held data", rsp_data, 8'h05);
    chk("R9 cmd stalled", {7'h0, cmd_ready}, 8'h00);
    cmd_valid = 1'b1; cmd_data = 8'hF5; cmd_last = 1'b1; rsp_ready = 1'b1;
    #1;
    chk("R11 ready with drain", {7'h0, cmd_ready}, 8'h01);
    chk("R11 old byte taken", rsp_data, 8'h05);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_last = 1'b0;
    chk("R11 drained", {7'h0, rsp_valid}, 8'h00);
    send_byte(8'h01, 1);
    chk("R11 new sample", rsp_data, 8'h0A);
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_mode();
    t_truncated();
    t_unknown_drain();
    t_sample_fetch();
    t_backpressure_overlap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule